// File: doc/BRIEF.md
# I2C Byte EEPROM Target

This block is a synthesizable I2C target that looks to a bus master like a small serial EEPROM. It holds 256 bytes and keeps an 8-bit word-address pointer. The master can store one byte with a single-byte write. It can fetch one byte with a random read, which sets the pointer, issues a repeated start and then reads back. A read that opens directly with the read address returns the byte at the pointer as it stands.

The block samples the bus clock and data lines through synchronizers and finds the bus edges, start conditions and stop conditions in the system clock domain. It never drives the data line high. Its only output is a drive-low enable for an open-drain pad, so the line is pulled low while the enable is 1 and released while it is 0. A start restarts address reception in any state, and a stop returns the block to idle from any state.

Top module: `eeprom_i2c_target`

## Requirements
- R1: After reset the drive-low enable is 0 and every memory byte reads back as 0x00.
- R2: A device address byte whose upper seven bits are 1010000 is acknowledged by holding SDA low for the whole ninth SCL clock. Byte 0xA0 selects a write and byte 0xA1 selects a read.
- R3: A device address byte with any other upper seven bits gets no acknowledge. The target keeps SDA released, acknowledges none of the bytes that follow and changes no memory until the next start.
- R4: In a write transaction (0xA0, word address, data byte, stop), each of the three bytes is acknowledged. The data byte is stored at the word address. Bits are taken MSB first, one per SCL rising edge.
- R5: In a random read (0xA0, word address, repeated start, 0xA1), the target returns the byte stored at that address, MSB first. It pulls SDA low for a 0 bit and releases SDA for a 1 bit.
- R6: The drive-low enable changes only on the third system clock after a bus SCL falling edge, start or stop appears at the inputs. Two of those clocks are the default synchronizer stages and the third is the output register. It never changes at any other time.
- R7: After the eighth bit of a read byte, the target releases SDA for the master's acknowledge clock. It then stays released and acknowledges nothing until the next start, even if SCL keeps toggling.
- R8: The word-address pointer survives repeated starts and stops. A transaction that opens with 0xA1 directly after a start returns the byte at the last word address loaded.
- R9: A start in the middle of a byte abandons the bits received so far and begins a new device address.
- R10: A stop in any state returns the target to idle. A partly received data byte is discarded and memory is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level, as seen on the wired bus |
| sdaDriveLow | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The assertions check on every cycle that the enable moves only after an SCL fall, start or stop. They also check that it is held during acknowledge states, that it is off in idle, in the wait-for-stop state and during the master's acknowledge clock, and that a start or stop sends the control to the right state. Whether a byte lands at the right address, whether a read returns it MSB first, and whether the pointer survives a repeated start can only be shown by the bench's bus scenarios. Those scenarios compare every returned bit, and the drive-low enable on every clock, against a behavioural model of the transaction.

// File: rtl/eeprom_tgt_pkg.sv
package eeprom_tgt_pkg;

  // Control states; the ack states split by the direction chosen in the address byte.
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK_DEVW,
    ST_ACK_DEVR,
    ST_WADR,
    ST_ACK_WADR,
    ST_WDAT,
    ST_ACK_WDAT,
    ST_RD_TX,
    ST_RD_ACK,
    ST_WAIT_STOP
  } tgtState_e;

  // One-cycle strobes from control to datapath.
  typedef struct packed {
    logic clrBits;
    logic shiftIn;
    logic loadPtr;
    logic writeMem;
    logic loadTx;
    logic shiftTx;
    logic driveAck;
    logic releaseSda;
  } tgtStrobe_t;

endpackage

// File: rtl/eeprom_tgt_sync.sv
module eeprom_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaBit,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  localparam int LINES = 2;

  logic [LINES-1:0] rawIn;
  logic [LINES-1:0] syncd;
  logic             sclLast;
  logic             sdaLast;
  logic             sclLvl;

  assign rawIn = {sdaIn, sclIn};

  // Each line gets its own flop chain, reset to the idle-high bus level.
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[STAGES-2:0], rawIn[g]};
    end
    assign syncd[g] = chain[STAGES-1];
  end

  assign sclLvl = syncd[0];
  assign sdaBit = syncd[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclLast <= 1'b1;
      sdaLast <= 1'b1;
    end else begin
      sclLast <= sclLvl;
      sdaLast <= sdaBit;
    end
  end

  assign sclRise  = sclLvl & ~sclLast;
  assign sclFall  = ~sclLvl & sclLast;
  // Data moving while the clock stays high marks a bus condition.
  assign startDet = sclLvl & sclLast & sdaLast & ~sdaBit;
  assign stopDet  = sclLvl & sclLast & ~sdaLast & sdaBit;

endmodule

// File: rtl/eeprom_tgt_data.sv
module eeprom_tgt_data
  import eeprom_tgt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tgtStrobe_t        strobe,
  input  logic              sdaBit,
  output logic [DATA_W-1:0] rxByte,
  output logic              byteDone,
  output logic              sdaDriveLow
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] txShift;
  logic [CNT_W-1:0]  bitCnt;
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] memRd;

  assign memRd    = mem[ptr];
  assign rxByte   = rxShift;
  assign byteDone = (bitCnt == CNT_W'(DATA_W));

  // Receive shifter: one bit per SCL rise, MSB first.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      bitCnt  <= '0;
    end else if (strobe.clrBits) begin
      bitCnt  <= '0;
    end else if (strobe.shiftIn) begin
      rxShift <= {rxShift[DATA_W-2:0], sdaBit};
      bitCnt  <= bitCnt + 1'b1;
    end
  end

  // Word-address pointer, kept until the next word address arrives.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ptr <= '0;
    else if (strobe.loadPtr) ptr <= rxShift[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobe.writeMem) begin
      mem[ptr] <= rxShift;
    end
  end

  // Transmit shifter holds the bits still to be sent, MSB aligned.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               txShift <= '1;
    else if (strobe.loadTx)  txShift <= {memRd[DATA_W-2:0], 1'b1};
    else if (strobe.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b1};
  end

  // Open-drain enable: only ever pulls low.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sdaDriveLow <= 1'b0;
    else if (strobe.releaseSda) sdaDriveLow <= 1'b0;
    else if (strobe.driveAck)   sdaDriveLow <= 1'b1;
    else if (strobe.loadTx)     sdaDriveLow <= ~memRd[DATA_W-1];
    else if (strobe.shiftTx)    sdaDriveLow <= ~txShift[DATA_W-1];
  end

endmodule

// File: rtl/eeprom_tgt_ctrl.sv
module eeprom_tgt_ctrl
  import eeprom_tgt_pkg::*;
#(
  parameter int              DATA_W   = 8,
  parameter logic [DATA_W-2:0] DEV_ADDR = 7'h50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              byteDone,
  output tgtState_e         state,
  output tgtStrobe_t        strobe
);

  tgtState_e nxt;
  logic      addrHit;

  assign addrHit = (rxByte[DATA_W-1:1] == DEV_ADDR);

  always_comb begin
    nxt    = state;
    strobe = '0;
    if (startDet) begin
      nxt               = ST_DEV;
      strobe.clrBits    = 1'b1;
      strobe.releaseSda = 1'b1;
    end else if (stopDet) begin
      nxt               = ST_IDLE;
      strobe.releaseSda = 1'b1;
    end else begin
      case (state)
        ST_IDLE, ST_WAIT_STOP: ;
        ST_DEV: begin
          if (sclRise) strobe.shiftIn = 1'b1;
          else if (sclFall && byteDone) begin
            if (!addrHit) begin
              nxt               = ST_IDLE;
              strobe.releaseSda = 1'b1;
            end else begin
              nxt             = rxByte[0] ? ST_ACK_DEVR : ST_ACK_DEVW;
              strobe.driveAck = 1'b1;
            end
          end
        end
        ST_ACK_DEVW: begin
          if (sclFall) begin
            nxt               = ST_WADR;
            strobe.releaseSda = 1'b1;
            strobe.clrBits    = 1'b1;
          end
        end
        ST_ACK_DEVR: begin
          if (sclFall) begin
            nxt            = ST_RD_TX;
            strobe.loadTx  = 1'b1;
            strobe.clrBits = 1'b1;
          end
        end
        ST_WADR: begin
          if (sclRise) strobe.shiftIn = 1'b1;
          else if (sclFall && byteDone) begin
            nxt             = ST_ACK_WADR;
            strobe.loadPtr  = 1'b1;
            strobe.driveAck = 1'b1;
          end
        end
        ST_ACK_WADR: begin
          if (sclFall) begin
            nxt               = ST_WDAT;
            strobe.releaseSda = 1'b1;
            strobe.clrBits    = 1'b1;
          end
        end
        ST_WDAT: begin
          if (sclRise) strobe.shiftIn = 1'b1;
          else if (sclFall && byteDone) begin
            nxt             = ST_ACK_WDAT;
            strobe.writeMem = 1'b1;
            strobe.driveAck = 1'b1;
          end
        end
        ST_ACK_WDAT: begin
          if (sclFall) begin
            nxt               = ST_WAIT_STOP;
            strobe.releaseSda = 1'b1;
          end
        end
        ST_RD_TX: begin
          // Rising edges only count bits here; the byte goes out on falls.
          if (sclRise) strobe.shiftIn = 1'b1;
          else if (sclFall) begin
            if (byteDone) begin
              nxt               = ST_RD_ACK;
              strobe.releaseSda = 1'b1;
            end else begin
              strobe.shiftTx = 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) nxt = ST_WAIT_STOP;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
  import eeprom_tgt_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 8,
  parameter logic [DATA_W-2:0] DEV_ADDR    = 7'h50
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaDriveLow
);

  logic              sdaBit;
  logic              sclRise;
  logic              sclFall;
  logic              startDet;
  logic              stopDet;
  tgtState_e         state;
  tgtStrobe_t        strobe;
  logic [DATA_W-1:0] rxByte;
  logic              byteDone;

  eeprom_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .sdaBit   (sdaBit),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet)
  );

  eeprom_tgt_ctrl #(.DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet),
    .rxByte   (rxByte),
    .byteDone (byteDone),
    .state    (state),
    .strobe   (strobe)
  );

  eeprom_tgt_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .sdaBit      (sdaBit),
    .rxByte      (rxByte),
    .byteDone    (byteDone),
    .sdaDriveLow (sdaDriveLow)
  );

endmodule

// File: rtl/eeprom_i2c_target_chk.sv
module eeprom_i2c_target_chk
  import eeprom_tgt_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-2:0] DEV_ADDR = 7'h50
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdaDriveLow,
  input tgtState_e         state,
  input logic              sclFall,
  input logic              startDet,
  input logic              stopDet,
  input logic              byteDone,
  input logic [DATA_W-1:0] rxByte
);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaDriveLow);

  // R4
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACK_DEVW || state == ST_ACK_DEVR ||
     state == ST_ACK_WADR || state == ST_ACK_WDAT) |-> sdaDriveLow);

  // R3
  mismatch_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEV && sclFall && byteDone && !startDet && !stopDet &&
     rxByte[DATA_W-1:1] != DEV_ADDR) |=> (state == ST_IDLE && !sdaDriveLow));

  // R6
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sclFall && !startDet && !stopDet) |=> $stable(sdaDriveLow));

  // R7
  read_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD_ACK || state == ST_WAIT_STOP) |-> !sdaDriveLow);

  // R9
  start_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_DEV && !sdaDriveLow));

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopDet && !startDet) |=> (state == ST_IDLE));

endmodule

bind eeprom_i2c_target eeprom_i2c_target_chk #(
  .DATA_W   (DATA_W),
  .DEV_ADDR (DEV_ADDR)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sdaDriveLow (sdaDriveLow),
  .state       (state),
  .sclFall     (sclFall),
  .startDet    (startDet),
  .stopDet     (stopDet),
  .byteDone    (byteDone),
  .rxByte      (rxByte)
);

// File: tb/eeprom_i2c_target_tb.sv
module eeprom_i2c_target_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SLOT       = 40;
  localparam int LAT        = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaDriveLow;
  wire  sdaBus = mSda & ~sdaDriveLow;

  int checks = 0;
  int errors = 0;
  bit cmpOn = 1'b0;
  bit done = 1'b0;
  logic expCur = 1'b0;
  logic [LAT-1:0] expHist = '0;
  logic lastSda = 1'b1;
  logic [7:0] refMem [256];
  logic [7:0] refPtr = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_i2c_target u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (mScl),
    .sdaIn       (sdaBus),
    .sdaDriveLow (sdaDriveLow)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One system clock: compare the drive enable against the delayed model, then set the bus.
  task automatic tick(input logic s, input logic d);
    @(negedge clk);
    if (cmpOn) begin
      checks++;
      if (sdaDriveLow !== expHist[LAT-1]) begin
        errors++;
        $display("FAIL R6 cycle compare: got %b expected %b at %0t",
                 sdaDriveLow, expHist[LAT-1], $time);
      end
    end
    mScl = s;
    mSda = d;
    expHist = {expHist[LAT-2:0], expCur};
  endtask

  // One bit clock; nextExp is what the target should drive once SCL falls at its end.
  task automatic slot(input logic mBit, input logic nextExp, output logic seen);
    seen = 1'b1;
    for (int t = 0; t < SLOT; t++) begin
      if (t == 30) expCur = nextExp;
      tick((t >= 10 && t < 30), (t < 5) ? lastSda : mBit);
      if (t == 20) seen = sdaBus;
    end
    lastSda = mBit;
  endtask

  task automatic startCond();
    for (int t = 0; t < SLOT; t++) begin
      if (t == 20) expCur = 1'b0;
      tick((t >= 10 && t < 30), (t < 5) ? lastSda : (t < 20));
    end
    lastSda = 1'b0;
  endtask

  task automatic stopCond();
    for (int t = 0; t < SLOT; t++) begin
      if (t == 20) expCur = 1'b0;
      tick((t >= 10), (t < 5) ? lastSda : (t >= 20));
    end
    lastSda = 1'b1;
  endtask

  task automatic sendByte(input logic [7:0] b, input logic ackExp, input logic afterAck,
                          output logic ackSeen);
    logic s;
    for (int i = 7; i >= 0; i--) slot(b[i], (i == 0) ? ackExp : 1'b0, s);
    slot(1'b1, afterAck, ackSeen);
  endtask

  task automatic recvByte(input logic [7:0] expByte, output logic [7:0] got);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      slot(1'b1, (i > 0) ? ~expByte[i-1] : 1'b0, s);
      got[i] = s;
    end
    slot(1'b1, 1'b0, s);  // master NACK
  endtask

  task automatic writeBody(input logic [7:0] addr, input logic [7:0] data, input string tag);
    logic a;
    sendByte(8'hA0, 1'b1, 1'b0, a); checkEq({tag, " R2 dev ack"}, a, 0);
    sendByte(addr,  1'b1, 1'b0, a); checkEq({tag, " R4 addr ack"}, a, 0);
    sendByte(data,  1'b1, 1'b0, a); checkEq({tag, " R4 data ack"}, a, 0);
    stopCond();
    refMem[addr] = data;
    refPtr = addr;
  endtask

  task automatic writeTxn(input logic [7:0] addr, input logic [7:0] data, input string tag);
    startCond();
    writeBody(addr, data, tag);
  endtask

  task automatic readTxn(input logic [7:0] addr, input bit extra, input string tag);
    logic a;
    logic [7:0] got;
    startCond();
    sendByte(8'hA0, 1'b1, 1'b0, a); checkEq({tag, " R2 dev ack"}, a, 0);
    sendByte(addr,  1'b1, 1'b0, a); checkEq({tag, " R5 addr ack"}, a, 0);
    refPtr = addr;
    startCond();
    sendByte(8'hA1, 1'b1, ~refMem[addr][7], a); checkEq({tag, " R2 read ack"}, a, 0);
    recvByte(refMem[addr], got);
    checkEq({tag, " R5 data"}, got, refMem[addr]);
    if (extra) begin
      sendByte(8'h3C, 1'b0, 1'b0, a);
      checkEq({tag, " R7 no ack after nack"}, a, 1);
    end
    stopCond();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b1, lastSda);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic a;
    logic s;
    logic [7:0] got;
    for (int i = 0; i < 256; i++) refMem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 reset drive", sdaDriveLow, 0);
    cmpOn = 1'b1;
    idle(10);

    // R1: unwritten location reads back zero
    readTxn(8'h10, 1'b0, "R1 reset memory");

    // R4 / R5: writes and reads with varied patterns, including address boundaries
    writeTxn(8'h05, 8'h3C, "w05");
    writeTxn(8'h00, 8'hA5, "w00");
    writeTxn(8'hFF, 8'h81, "wFF");
    readTxn(8'h05, 1'b0, "r05");
    readTxn(8'h00, 1'b0, "r00");
    readTxn(8'hFF, 1'b0, "rFF");
    writeTxn(8'h05, 8'hC3, "w05b");
    readTxn(8'h05, 1'b0, "r05b");

    // R8: current-address read after a stop uses the last loaded pointer
    startCond();
    sendByte(8'hA1, 1'b1, ~refMem[refPtr][7], a);
    checkEq("R8 ack", a, 0);
    recvByte(refMem[refPtr], got);
    checkEq("R8 current address data", got, refMem[refPtr]);
    stopCond();

    // R3: foreign device addresses are ignored along with the bytes after them
    startCond();
    sendByte(8'hB0, 1'b0, 1'b0, a); checkEq("R3 no ack B0", a, 1);
    sendByte(8'h05, 1'b0, 1'b0, a); checkEq("R3 no ack follow", a, 1);
    sendByte(8'h77, 1'b0, 1'b0, a); checkEq("R3 no ack data", a, 1);
    stopCond();
    startCond();
    sendByte(8'hA2, 1'b0, 1'b0, a); checkEq("R3 no ack A2", a, 1);
    stopCond();
    readTxn(8'h05, 1'b0, "R3 memory kept");

    // R9: start in the middle of a byte restarts address reception
    startCond();
    slot(1'b1, 1'b0, s); slot(1'b0, 1'b0, s); slot(1'b1, 1'b0, s); slot(1'b1, 1'b0, s);
    startCond();
    writeBody(8'h22, 8'h5A, "R9 restart");
    readTxn(8'h22, 1'b0, "R9 readback");

    // R10: stop in the middle of a data byte discards it
    startCond();
    sendByte(8'hA0, 1'b1, 1'b0, a); checkEq("R10 dev ack", a, 0);
    sendByte(8'h40, 1'b1, 1'b0, a); checkEq("R10 addr ack", a, 0);
    refPtr = 8'h40;
    slot(1'b1, 1'b0, s); slot(1'b1, 1'b0, s); slot(1'b0, 1'b0, s);
    stopCond();
    readTxn(8'h40, 1'b0, "R10 memory kept");

    // R7: after the NACK the target stays off the bus
    readTxn(8'hFF, 1'b1, "R7 release");

    idle(20);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule